// File: doc/BRIEF.md
# Palette Lookup and Pixel Unpacking Stage

This block sits between the frame-buffer fetch logic and the display output of an LCD controller. A register bus loads a colour table of 128 thirty-two-bit words, and each word carries two sixteen-bit colour entries, so the table has 256 entries. The bus sees these words in the offset window 0x200 to 0x3FF and can read them back unchanged.

On the pixel side the block takes one thirty-two-bit frame-buffer word at a time, along with a depth code and three ordering controls. It produces one 24-bit colour per cycle under a valid/ready handshake. At 1, 2, 4 and 8 bits per pixel each pixel value indexes the colour table. At 16 bits per pixel the pixel is decoded directly as 5:5:5 colour. At 32 bits per pixel its low three bytes are used as the colour.

Top module: `pal_pixel_expander`

## Requirements
- R1: A bus write with `bus_addr` in 0x200..0x3FF stores `bus_wdata` at word (`bus_addr`-0x200)>>2. `bus_rdata` returns the stored word for the address presented one cycle earlier. Addresses outside the window read as zero, and writes to them change no stored word.
- R2: Colour index 2n uses bits 15:0 of stored word n, and index 2n+1 uses bits 31:16.
- R3: In a 16-bit colour entry, bits 4:0 give red, bits 9:5 give green and bits 14:10 give blue. Each 5-bit field is shifted left by three with zero fill, and bit 15 has no effect. `out_rgb` carries red in 23:16, green in 15:8 and blue in 7:0.
- R4: `in_depth` codes 0..5 select 1, 2, 4, 8, 16 and 32 bits per pixel. Each input word yields 32 divided by that width pixels.
- R5: With both ordering controls low, pixels are taken from the least significant bits of the word upward.
- R6: With `in_be_byte` high, the four bytes of the word are reversed first (byte 3 becomes byte 0). Extraction then proceeds as in R5, and `in_be_pix` is ignored.
- R7: With `in_be_byte` low and `in_be_pix` high, the pixel order inside each byte is reversed at 1, 2 and 4 bits per pixel. At 8 bits per pixel and above this control has no effect.
- R8: With `in_bgr` high, the red and blue bytes of `out_rgb` are exchanged.
- R9: At 16 bits per pixel the pixel is decoded as in R3 without a table lookup. At 32 bits per pixel, bits 7:0 give red, bits 15:8 give green and bits 23:16 give blue.
- R10: After reset `out_valid` is low and `in_ready` is high. While `out_valid` is high and `out_ready` is low, `out_rgb` holds. A new word is accepted only when no pixels remain or the last one leaves in the same cycle.
- R11: A table write takes effect for lookups made from the next clock cycle on. A lookup in the same cycle as the write sees the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the previous cycle's address |
| in_valid | input | 1 | Frame word offered |
| in_ready | output | 1 | Frame word taken this cycle |
| in_word | input | 32 | Frame-buffer word |
| in_depth | input | 3 | Bits-per-pixel code, 0..5 |
| in_bgr | input | 1 | Exchange red and blue |
| in_be_byte | input | 1 | Reverse byte order |
| in_be_pix | input | 1 | Reverse pixel order inside bytes |
| out_valid | output | 1 | Pixel available |
| out_ready | input | 1 | Pixel taken |
| out_rgb | output | 24 | Pixel colour, red high |

## Verification
The checks assume that `in_depth` never carries codes 6 or 7 while `in_valid` is high. The stimulus table only holds codes 0 through 5. They also assume that a word on the input stays put until it is taken, and the driver holds every input field steady across stalled cycles. Table writes happen only while no lookup is pending, except in one directed case. That case deliberately places a write on the same edge as the first lookup of a word.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

  // depth codes whose numeric order the datapath depends on
  localparam logic [2:0] DEP_8  = 3'd3;
  localparam logic [2:0] DEP_16 = 3'd4;
  localparam logic [2:0] DEP_32 = 3'd5;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;

  // 5:5:5 colour field widened to 8:8:8 with zero fill
  function automatic rgb_t unpack555(input logic [14:0] c);
    rgb_t o;
    o.r = {c[4:0],   3'b000};
    o.g = {c[9:5],   3'b000};
    o.b = {c[14:10], 3'b000};
    return o;
  endfunction

endpackage

// File: rtl/pxu_palette.sv
module pxu_palette #(
  parameter int                 PAL_WORDS = 128,
  parameter int                 ADDR_W    = 12,
  parameter logic [ADDR_W-1:0]  PAL_BASE  = 12'h200,
  localparam int                IDX_W     = $clog2(PAL_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              lk_en,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic [29:0]       lk_pair
);

  localparam logic [ADDR_W:0] WIN_END =
    (ADDR_W+1)'(PAL_BASE) + (ADDR_W+1)'(PAL_WORDS * 4);

  logic [31:0]      mem [PAL_WORDS];
  logic [31:0]      a_q;
  logic [29:0]      b_q;
  logic             win_q;
  logic             win;
  logic [IDX_W-1:0] a_idx;

  assign win   = (bus_addr >= PAL_BASE) && ({1'b0, bus_addr} < WIN_END);
  assign a_idx = IDX_W'((bus_addr - PAL_BASE) >> 2);

  // port A: bus write and read-first read; port B: lookup read
  always_ff @(posedge clk) begin
    if (bus_wr && win) mem[a_idx] <= bus_wdata;
    a_q <= mem[a_idx];
  end

  always_ff @(posedge clk) begin
    if (lk_en) b_q <= {mem[lk_idx][30:16], mem[lk_idx][14:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) win_q <= 1'b0;
    else     win_q <= win;
  end

  assign bus_rdata = win_q ? a_q : '0;
  assign lk_pair   = b_q;

endmodule

// File: rtl/pxu_slicer.sv
module pxu_slicer
  import pxu_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  logic [2:0]        in_depth,
  input  logic              in_bgr,
  input  logic              in_be_byte,
  input  logic              in_be_pix,
  output logic              in_ready,
  input  logic              adv,
  output logic              px_avail,
  output logic [23:0]       px_val,
  output logic [2:0]        px_depth,
  output logic              px_bgr
);

  localparam int POS_W = $clog2(WORD_W);
  localparam int NBYTE = WORD_W / 8;

  logic              busy;
  logic [WORD_W-1:0] w_q;
  logic [2:0]        dep_q;
  logic              bgr_q, bep_q;
  logic [POS_W-1:0]  k_q, k_last, off;
  logic [WORD_W-1:0] swapped, mask;
  logic              last_px;

  for (genvar b = 0; b < NBYTE; b++) begin : g_swap
    assign swapped[8*b +: 8] = in_word[8*(NBYTE-1-b) +: 8];
  end

  assign k_last  = POS_W'((WORD_W >> dep_q) - 1);
  assign last_px = busy && (k_q == k_last);
  assign in_ready = !busy || (last_px && adv);

  always_comb begin
    off = POS_W'(k_q << dep_q);
    if (bep_q) begin
      case (dep_q)
        3'd0:    off[2:0] = off[2:0] ^ 3'd7;
        3'd1:    off[2:0] = off[2:0] ^ 3'd6;
        3'd2:    off[2:0] = off[2:0] ^ 3'd4;
        default: ;
      endcase
    end
  end

  always_comb begin
    if (dep_q >= DEP_32) mask = '1;
    else                 mask = (WORD_W'(1) << (1 << dep_q)) - WORD_W'(1);
  end

  assign px_val   = 24'((w_q >> off) & mask);
  assign px_avail = busy;
  assign px_depth = dep_q;
  assign px_bgr   = bgr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      w_q   <= '0;
      dep_q <= '0;
      bgr_q <= 1'b0;
      bep_q <= 1'b0;
      k_q   <= '0;
    end else if (in_valid && in_ready) begin
      busy  <= 1'b1;
      w_q   <= in_be_byte ? swapped : in_word;
      dep_q <= in_depth;
      bgr_q <= in_bgr;
      bep_q <= in_be_pix && !in_be_byte;
      k_q   <= '0;
    end else if (adv) begin
      if (k_q == k_last) busy <= 1'b0;
      else               k_q  <= k_q + 1'b1;
    end
  end

  assert_depth_legal_R4: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> in_depth <= DEP_32)
    else $error("depth code out of range");

  assert_index_bound_R4: assert property (@(posedge clk) disable iff (rst)
    busy |-> k_q <= k_last)
    else $error("pixel index beyond word");

  assert_word_held_R10: assert property (@(posedge clk) disable iff (rst)
    busy && !adv |=> busy && $stable(w_q) && $stable(k_q))
    else $error("word state moved without a pixel leaving");

endmodule

// File: rtl/pal_pixel_expander.sv
module pal_pixel_expander
  import pxu_pkg::*;
#(
  parameter int                PAL_WORDS = 128,
  parameter int                ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] PAL_BASE  = 12'h200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_word,
  input  logic [2:0]        in_depth,
  input  logic              in_bgr,
  input  logic              in_be_byte,
  input  logic              in_be_pix,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [23:0]       out_rgb
);

  localparam int IDX_W = $clog2(PAL_WORDS);

  logic        px_avail, px_bgr, adv;
  logic [23:0] px_val;
  logic [2:0]  px_depth;
  logic [29:0] lk_pair;

  logic        ov_q, ix_q, half_q, bgr_q;
  rgb_t        dir_q, dir_rgb, pal_rgb, sel;
  logic [14:0] entry;

  pxu_palette #(
    .PAL_WORDS (PAL_WORDS),
    .ADDR_W    (ADDR_W),
    .PAL_BASE  (PAL_BASE)
  ) u_pal (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .lk_en     (adv),
    .lk_idx    (px_val[IDX_W:1]),
    .lk_pair   (lk_pair)
  );

  pxu_slicer #(.WORD_W(32)) u_slice (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_word    (in_word),
    .in_depth   (in_depth),
    .in_bgr     (in_bgr),
    .in_be_byte (in_be_byte),
    .in_be_pix  (in_be_pix),
    .in_ready   (in_ready),
    .adv        (adv),
    .px_avail   (px_avail),
    .px_val     (px_val),
    .px_depth   (px_depth),
    .px_bgr     (px_bgr)
  );

  assign adv = px_avail && (!ov_q || out_ready);

  always_comb begin
    if (px_depth == DEP_16) dir_rgb = unpack555(px_val[14:0]);
    else begin
      dir_rgb.r = px_val[7:0];
      dir_rgb.g = px_val[15:8];
      dir_rgb.b = px_val[23:16];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ov_q   <= 1'b0;
      ix_q   <= 1'b0;
      half_q <= 1'b0;
      bgr_q  <= 1'b0;
      dir_q  <= '0;
    end else if (adv) begin
      ov_q   <= 1'b1;
      ix_q   <= (px_depth <= DEP_8);
      half_q <= px_val[0];
      bgr_q  <= px_bgr;
      dir_q  <= dir_rgb;
    end else if (out_ready) begin
      ov_q   <= 1'b0;
    end
  end

  assign entry   = half_q ? lk_pair[29:15] : lk_pair[14:0];
  assign pal_rgb = unpack555(entry);
  assign sel     = ix_q ? pal_rgb : dir_q;
  assign out_rgb = bgr_q ? {sel.b, sel.g, sel.r} : {sel.r, sel.g, sel.b};
  assign out_valid = ov_q;

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_rgb))
    else $error("pixel changed while stalled");

  assert_valid_origin_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(px_avail))
    else $error("pixel appeared with no word loaded");

  assert_low_bits_zero_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid && ix_q |-> out_rgb[2:0] == 3'd0 && out_rgb[10:8] == 3'd0
                          && out_rgb[18:16] == 3'd0)
    else $error("table colour not zero-filled");

endmodule

// File: tb/sim_pal_pixel_expander.sv
module sim_pal_pixel_expander;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic [2:0]  in_depth = '0;
  logic        in_bgr = 1'b0, in_be_byte = 1'b0, in_be_pix = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [23:0] out_rgb;

  always #5 clk = ~clk;

  pal_pixel_expander u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .in_valid(in_valid),
    .in_ready(in_ready), .in_word(in_word), .in_depth(in_depth),
    .in_bgr(in_bgr), .in_be_byte(in_be_byte), .in_be_pix(in_be_pix),
    .out_valid(out_valid), .out_ready(out_ready), .out_rgb(out_rgb)
  );

  int total = 0;
  int fails = 0;
  int cyc = 0;
  int rmode = 0;
  logic [31:0] pal_model [128];
  logic [23:0] exp_q [$];
  string       tag_q [$];
  logic        stalled_prev = 1'b0;
  logic [23:0] held = '0;

  // {depth[39:37], bgr[36], be_byte[35], be_pix[34], 2'b0, word}
  localparam int NV = 15;
  localparam logic [39:0] VEC [NV] = '{
    {3'd3, 3'b000, 2'b00, 32'h8041_FF02},
    {3'd0, 3'b000, 2'b00, 32'hA5C3_0F81},
    {3'd1, 3'b000, 2'b00, 32'h1B2D_E487},
    {3'd2, 3'b000, 2'b00, 32'hFEDC_BA98},
    {3'd4, 3'b000, 2'b00, 32'hFFFF_7C1F},
    {3'd5, 3'b000, 2'b00, 32'h1234_5678},
    {3'd2, 3'b010, 2'b00, 32'h0123_4567},
    {3'd4, 3'b010, 2'b00, 32'hABCD_1234},
    {3'd0, 3'b001, 2'b00, 32'h8001_C003},
    {3'd1, 3'b001, 2'b00, 32'hE41B_9C36},
    {3'd3, 3'b001, 2'b00, 32'h1122_3344},
    {3'd2, 3'b011, 2'b00, 32'h89AB_CDEF},
    {3'd3, 3'b100, 2'b00, 32'h0010_2030},
    {3'd5, 3'b110, 2'b00, 32'hCAFE_F00D},
    {3'd4, 3'b100, 2'b00, 32'h7FFF_0421}
  };

  function automatic logic [31:0] pal_init(int n);
    return {16'(n * 16'h2468 + 16'h0F0F), 16'((n * 16'h1357) ^ 16'h8421)};
  endfunction

  function automatic logic [23:0] exp_px(logic [31:0] word, int d, bit bgr,
                                         bit beb, bit bep, int k);
    logic [7:0]  by [4];
    logic [31:0] val, pw;
    logic [15:0] e;
    logic [7:0]  r, g, bl;
    int bpp, ppb, b, j, nb;
    for (int i = 0; i < 4; i++) by[i] = beb ? word[8*(3-i) +: 8] : word[8*i +: 8];
    bpp = 1 << d;
    val = '0;
    if (bpp >= 8) begin
      nb = bpp / 8;
      for (int i = 0; i < nb; i++) val = val | (32'(by[k*nb+i]) << (8*i));
    end else begin
      ppb = 8 / bpp;
      b = k / ppb;
      j = k % ppb;
      if (bep && !beb) j = ppb - 1 - j;
      val = (32'(by[b]) >> (j*bpp)) & ((32'd1 << bpp) - 32'd1);
    end
    if (d == 5) begin
      r = val[7:0]; g = val[15:8]; bl = val[23:16];
    end else begin
      if (d <= 3) begin
        pw = pal_model[val[7:1]];
        e = val[0] ? pw[31:16] : pw[15:0];
      end else e = val[15:0];
      r = {e[4:0], 3'b000}; g = {e[9:5], 3'b000}; bl = {e[14:10], 3'b000};
    end
    return bgr ? {bl, g, r} : {r, g, bl};
  endfunction

  function automatic string tag_of(int d, bit bgr, bit beb, bit bep);
    if (beb) return "R6";
    if (bep) return "R7";
    if (bgr) return "R8";
    if (d >= 4) return "R9";
    if (d < 3) return "R4/R5";
    return "R2/R3";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    @(negedge clk);
    #2 d = bus_rdata;
  endtask

  task automatic send_word(logic [31:0] w, int d, bit bgr, bit beb, bit bep, bit push);
    bit acc;
    if (push) begin
      for (int k = 0; k < (32 >> d); k++) begin
        exp_q.push_back(exp_px(w, d, bgr, beb, bep, k));
        tag_q.push_back(tag_of(d, bgr, beb, bep));
      end
    end
    @(negedge clk);
    in_word = w; in_depth = 3'(d); in_bgr = bgr; in_be_byte = beb;
    in_be_pix = bep; in_valid = 1'b1;
    forever begin
      #2 acc = in_ready;
      @(posedge clk);
      if (acc) break;
      @(negedge clk);
    end
    #1 in_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R10 leftover pixels", 32'(exp_q.size()), 32'd0);
  endtask

  // output consumer: ready pattern, stall hold and pixel comparison
  always begin
    @(negedge clk);
    cyc++;
    out_ready = (rmode == 0) ? 1'b1 : (rmode == 1) ? (cyc % 3 != 1) : 1'b0;
    #2;
    if (stalled_prev) begin
      total++;
      if (!out_valid || out_rgb !== held) begin
        fails++;
        $display("FAIL R10 stall hold: actual %b/%h expected 1/%h", out_valid, out_rgb, held);
      end
    end
    stalled_prev = out_valid && !out_ready;
    held = out_rgb;
    if (out_valid && out_ready) begin
      total++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R10 extra pixel: actual %h expected none", out_rgb);
      end else begin
        logic [23:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (out_rgb !== e) begin
          fails++;
          $display("FAIL %s pixel: actual %h expected %h", t, out_rgb, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", total, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd, old_w, new_w;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #2;
    check("R10 reset out_valid", 32'(out_valid), 32'd0);
    check("R10 reset in_ready", 32'(in_ready), 32'd1);
    check("R1 reset rdata", bus_rdata, 32'd0);

    for (int n = 0; n < 128; n++) begin
      pal_model[n] = pal_init(n);
      bus_write(12'h200 + 12'(n * 4), pal_model[n]);
    end

    // R1: readback and window edges
    bus_read(12'h214, rd);  check("R1 readback word 5", rd, pal_model[5]);
    bus_read(12'h3FC, rd);  check("R1 readback word 127", rd, pal_model[127]);
    bus_write(12'h1FC, 32'hDEAD_BEEF);
    bus_write(12'h400, 32'h1234_5678);
    bus_read(12'h3FC, rd);  check("R1 below-window write ignored", rd, pal_model[127]);
    bus_read(12'h200, rd);  check("R1 above-window write ignored", rd, pal_model[0]);
    bus_read(12'h1FC, rd);  check("R1 below-window read", rd, 32'd0);
    bus_read(12'h400, rd);  check("R1 above-window read", rd, 32'd0);

    // table of pixel vectors, steady then bursty consumer
    rmode = 0;
    for (int v = 0; v < NV; v++) begin
      if (v == 8) rmode = 1;
      send_word(VEC[v][31:0], int'(VEC[v][39:37]), VEC[v][36], VEC[v][35], VEC[v][34], 1'b1);
    end
    drain();

    // R10: word held back while the consumer stalls
    rmode = 2;
    send_word(32'h0000_00A5, 0, 1'b0, 1'b0, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    #2;
    check("R10 in_ready low with pixels left", 32'(in_ready), 32'd0);
    check("R10 out_valid during stall", 32'(out_valid), 32'd1);
    rmode = 0;
    drain();

    // R11: write lands on the edge of the first lookup
    old_w = pal_model[2];
    new_w = 32'h0000_03E0;
    exp_q.push_back(exp_px(32'h0404_0404, 3, 1'b0, 1'b0, 1'b0, 0));
    tag_q.push_back("R11 same-cycle lookup");
    pal_model[2] = new_w;
    for (int k = 1; k < 4; k++) begin
      exp_q.push_back(exp_px(32'h0404_0404, 3, 1'b0, 1'b0, 1'b0, k));
      tag_q.push_back("R11 next-cycle lookup");
    end
    send_word(32'h0404_0404, 3, 1'b0, 1'b0, 1'b0, 1'b0);
    bus_write(12'h208, new_w);
    drain();
    bus_read(12'h208, rd);
    check("R11 stored word", rd, new_w);
    if (old_w == new_w) check("R11 test setup", old_w, ~new_w);

    $display("== %0d vectors applied, %0d miscompares ==", total, fails);
    $finish;
  end

endmodule